// File: doc/BRIEF.md
# Exception Priority and Vectoring Unit

This unit collects every exception request a processor can raise in a given cycle and selects exactly one to service. Requests come from the core as single-cycle strobes and from outside as a reset request, a bus error, and an encoded interrupt priority level. Each strobe is held in a pending flag until it is serviced. In each cycle the highest-priority pending request wins. For the winner, the unit issues a one-cycle take pulse, an 8-bit vector number, and the 32-bit byte address of the vector-table slot to fetch.

The unit compares interrupt levels against the mask field of the status register. Each accepted level maps onto the autovector range. Software traps are numbered 0 to 15 and map onto a vector range of their own. When an interrupt is accepted, an acknowledge pulse reports the level, so that the core can raise its mask to that level. Saving state, running bus cycles and decoding opcodes are left to the core.

Top module: `exc_vector_unit`

## Requirements
- R1: Every take pulse comes with `vec_addr_o` equal to the vector number times 4, zero-extended to 32 bits.
- R2: Core strobes select these vectors: divide-by-zero 5, bound check 6, overflow trap 7, privilege violation 8, illegal opcode 4, line-A opcode 10, line-F opcode 11.
- R3: A software trap with number n (0..15 on `trap_num_i`) selects vector 32+n.
- R4: A reset request selects vector 0 and a bus error selects vector 2. `instr_done_i` while `sr_trace_i` is 1 raises a trace request, which selects vector 9.
- R5: An accepted interrupt of level L (1..7) selects vector 24+L and pulses `ack_o` together with `take_o`, with `ack_level_o` equal to L.
- R6: Interrupt levels 1 to 6 are accepted only when the level is strictly greater than `sr_mask_i`. Otherwise `take_o` stays low.
- R7: Level 7 is accepted whatever the mask, once for each transition of the input level to 7. Holding the level at 7 gives no further takes.
- R8: Priority from highest to lowest is: reset, bus error, trace, interrupt, illegal, line-A, line-F, privilege, divide-by-zero, bound, overflow, trap.
- R9: Exactly one request is taken per cycle. Requests that lose stay pending and are taken in later cycles in priority order.
- R10: A reset request discards every other pending core or bus-error request that is latched in the same cycle or earlier.
- R11: While `rst_ni` is low, `take_o`, `ack_o`, `vec_num_o`, `vec_addr_o` and `ack_level_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reset_req_i | input | 1 | External reset request strobe |
| bus_err_i | input | 1 | Bus error strobe |
| irq_level_i | input | 3 | Encoded interrupt level, 0 means none |
| sr_mask_i | input | 3 | Status-register interrupt mask |
| sr_trace_i | input | 1 | Status-register trace bit |
| instr_done_i | input | 1 | Instruction completed strobe |
| illegal_i | input | 1 | Illegal opcode strobe |
| line_a_i | input | 1 | Line-A opcode strobe |
| line_f_i | input | 1 | Line-F opcode strobe |
| priv_i | input | 1 | Privilege violation strobe |
| div_zero_i | input | 1 | Divide-by-zero strobe |
| bound_i | input | 1 | Bound check strobe |
| ovf_trap_i | input | 1 | Overflow trap strobe |
| trap_i | input | 1 | Software trap strobe |
| trap_num_i | input | 4 | Software trap number |
| take_o | output | 1 | One-cycle take-exception pulse |
| vec_num_o | output | 8 | Selected vector number |
| vec_addr_o | output | 32 | Byte address of the vector-table entry |
| ack_o | output | 1 | Interrupt acknowledge pulse |
| ack_level_o | output | 3 | Level of the acknowledged interrupt |

## Verification
A strobe or interrupt level is registered at the first rising edge after it is driven. The winning request appears on `take_o`, `vec_num_o`, `vec_addr_o`, `ack_o` and `ack_level_o` after the second rising edge. The bench therefore drives inputs on a falling edge, removes strobes on the next falling edge, and samples the outputs on the falling edge after that. When several requests are pending at once, the later winners follow one per cycle. The bench samples on each following falling edge to check the drain order. For the cases where nothing may be taken (masked levels, a held level 7, requests discarded by reset), the bench counts take pulses over a window of idle cycles.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSRC    = 12;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int VEC_W   = 8;
  localparam int ADDR_W  = 32;
  localparam int LVL_W   = 3;
  localparam int TRAP_W  = 4;
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  // source index = priority rank, 0 highest
  localparam int SRC_RST   = 0;
  localparam int SRC_BUS   = 1;
  localparam int SRC_TRACE = 2;
  localparam int SRC_IRQ   = 3;
  localparam int SRC_ILL   = 4;
  localparam int SRC_LINEA = 5;
  localparam int SRC_LINEF = 6;
  localparam int SRC_PRIV  = 7;
  localparam int SRC_DIVZ  = 8;
  localparam int SRC_BOUND = 9;
  localparam int SRC_OVF   = 10;
  localparam int SRC_TRAP  = 11;

  localparam logic [VEC_W-1:0] VEC_IRQ_BASE  = 8'd24;
  localparam logic [VEC_W-1:0] VEC_TRAP_BASE = 8'd32;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx,
                                              input logic [LVL_W-1:0] lvl,
                                              input logic [TRAP_W-1:0] tnum);
    case (int'(idx))
      SRC_RST:   vec_of = 8'd0;
      SRC_BUS:   vec_of = 8'd2;
      SRC_TRACE: vec_of = 8'd9;
      SRC_IRQ:   vec_of = VEC_IRQ_BASE + VEC_W'(lvl);
      SRC_ILL:   vec_of = 8'd4;
      SRC_LINEA: vec_of = 8'd10;
      SRC_LINEF: vec_of = 8'd11;
      SRC_PRIV:  vec_of = 8'd8;
      SRC_DIVZ:  vec_of = 8'd5;
      SRC_BOUND: vec_of = 8'd6;
      SRC_OVF:   vec_of = 8'd7;
      default:   vec_of = VEC_TRAP_BASE + VEC_W'(tnum);
    endcase
  endfunction
endpackage

// File: rtl/exc_pending.sv
module exc_pending
  import exc_pkg::*;
#(
  parameter int N = NSRC,
  parameter logic [N-1:0] KEEP_ON_FLUSH = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         flush_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          pend_q[i] <= 1'b0;
      else if (flush_i && !KEEP_ON_FLUSH[i]) pend_q[i] <= 1'b0;
      else                                  pend_q[i] <= (pend_q[i] & ~clr_i[i]) | set_i[i];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/exc_irq_gate.sv
module exc_irq_gate
  import exc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             served_i,
  output logic             req_o,
  output logic [LVL_W-1:0] level_o
);
  logic [LVL_W-1:0] lvl_q, prev_q;
  logic             nmi_pend_q, nmi_edge, nmi_req, maskable;

  assign nmi_edge = (lvl_q == LVL_MAX) && (prev_q != LVL_MAX);
  assign nmi_req  = nmi_edge | nmi_pend_q;
  assign maskable = (lvl_q != '0) && (lvl_q != LVL_MAX) && (lvl_q > mask_i);
  assign req_o    = nmi_req | maskable;
  assign level_o  = nmi_req ? LVL_MAX : lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q      <= '0;
      prev_q     <= '0;
      nmi_pend_q <= 1'b0;
    end else begin
      lvl_q      <= irq_level_i;
      prev_q     <= lvl_q;
      nmi_pend_q <= nmi_req & ~served_i;
    end
  end
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_pkg::*;
#(
  parameter int N = NSRC,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !valid_o) begin
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
        valid_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reset_req_i,
  input  logic              bus_err_i,
  input  logic [LVL_W-1:0]  irq_level_i,
  input  logic [LVL_W-1:0]  sr_mask_i,
  input  logic              sr_trace_i,
  input  logic              instr_done_i,
  input  logic              illegal_i,
  input  logic              line_a_i,
  input  logic              line_f_i,
  input  logic              priv_i,
  input  logic              div_zero_i,
  input  logic              bound_i,
  input  logic              ovf_trap_i,
  input  logic              trap_i,
  input  logic [TRAP_W-1:0] trap_num_i,
  output logic              take_o,
  output logic [VEC_W-1:0]  vec_num_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              ack_o,
  output logic [LVL_W-1:0]  ack_level_o
);
  localparam logic [NSRC-1:0] KEEP_RST = NSRC'(1) << SRC_RST;

  logic [NSRC-1:0]   set_vec, pend, req_all, grant;
  logic [IDX_W-1:0]  win_idx;
  logic              win_valid, irq_req;
  logic [LVL_W-1:0]  irq_lvl;
  logic [TRAP_W-1:0] trap_num_q;
  logic              take_q, ack_q;
  logic [VEC_W-1:0]  vec_q;
  logic [LVL_W-1:0]  ack_lvl_q;

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_RST]   = reset_req_i;
    set_vec[SRC_BUS]   = bus_err_i;
    set_vec[SRC_TRACE] = instr_done_i & sr_trace_i;
    set_vec[SRC_ILL]   = illegal_i;
    set_vec[SRC_LINEA] = line_a_i;
    set_vec[SRC_LINEF] = line_f_i;
    set_vec[SRC_PRIV]  = priv_i;
    set_vec[SRC_DIVZ]  = div_zero_i;
    set_vec[SRC_BOUND] = bound_i;
    set_vec[SRC_OVF]   = ovf_trap_i;
    set_vec[SRC_TRAP]  = trap_i;
  end

  exc_pending #(.N(NSRC), .KEEP_ON_FLUSH(KEEP_RST)) u_pend (
    .clk_i, .rst_ni,
    .set_i  (set_vec),
    .clr_i  (grant),
    .flush_i(reset_req_i),
    .pend_o (pend)
  );

  exc_irq_gate u_irq (
    .clk_i, .rst_ni,
    .irq_level_i,
    .mask_i  (sr_mask_i),
    .served_i(grant[SRC_IRQ]),
    .req_o   (irq_req),
    .level_o (irq_lvl)
  );

  always_comb begin
    req_all          = pend;
    req_all[SRC_IRQ] = irq_req;
  end

  exc_prio_sel #(.N(NSRC)) u_sel (
    .req_i  (req_all),
    .grant_o(grant),
    .idx_o  (win_idx),
    .valid_o(win_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     trap_num_q <= '0;
    else if (trap_i) trap_num_q <= trap_num_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q    <= 1'b0;
      ack_q     <= 1'b0;
      vec_q     <= '0;
      ack_lvl_q <= '0;
    end else begin
      take_q <= win_valid;
      ack_q  <= grant[SRC_IRQ];
      if (win_valid)      vec_q     <= vec_of(win_idx, irq_lvl, trap_num_q);
      if (grant[SRC_IRQ]) ack_lvl_q <= irq_lvl;
    end
  end

  assign take_o      = take_q;
  assign ack_o       = ack_q;
  assign vec_num_o   = vec_q;
  assign vec_addr_o  = {{(ADDR_W-VEC_W-2){1'b0}}, vec_q, 2'b00};
  assign ack_level_o = ack_lvl_q;
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk
  import exc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reset_req_i,
  input logic [LVL_W-1:0]  sr_mask_i,
  input logic              take_o,
  input logic [VEC_W-1:0]  vec_num_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic              ack_o,
  input logic [LVL_W-1:0]  ack_level_o
);
  // R1
  vec_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vec_addr_o == {{(ADDR_W-VEC_W-2){1'b0}}, vec_num_o, 2'b00}));

  // R5
  ack_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (take_o && ack_level_o != '0 && vec_num_o == VEC_IRQ_BASE + VEC_W'(ack_level_o)));

  // R6
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ack_level_o != LVL_MAX) |-> (ack_level_o > $past(sr_mask_i)));

  // R10
  reset_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |=> ##1 (take_o && vec_num_o == '0));

  // R9
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vec_num_o < VEC_TRAP_BASE + 8'd16 && vec_num_o != 8'd3
                && !(vec_num_o > 8'd11 && vec_num_o < 8'd25)));

  // R11
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!take_o && !ack_o && vec_num_o == '0 && ack_level_o == '0));
endmodule

bind exc_vector_unit exc_vector_unit_chk u_chk (.*);

// File: tb/exc_vector_unit_test.sv
module exc_vector_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reset_req_i = 0, bus_err_i = 0, sr_trace_i = 0, instr_done_i = 0;
  logic [2:0]  irq_level_i = '0, sr_mask_i = '0;
  logic        illegal_i = 0, line_a_i = 0, line_f_i = 0, priv_i = 0;
  logic        div_zero_i = 0, bound_i = 0, ovf_trap_i = 0, trap_i = 0;
  logic [3:0]  trap_num_i = '0;
  logic        take_o, ack_o;
  logic [7:0]  vec_num_o;
  logic [31:0] vec_addr_o;
  logic [2:0]  ack_level_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  exc_vector_unit uut (.*);

  // req bits: 0 rst,1 bus,2 trace,4 ill,5 lineA,6 lineF,7 priv,8 divz,9 bound,10 ovf,11 trap
  // {req[11:0], irq[2:0], mask[2:0], trapn[3:0], vec[7:0], take, ack}
  localparam int NV = 21;
  localparam logic [31:0] TBL [NV] = '{
    {12'h100, 3'd0, 3'd0, 4'd0,  8'd5,  1'b1, 1'b0},  // R2 divz
    {12'h200, 3'd0, 3'd0, 4'd0,  8'd6,  1'b1, 1'b0},  // R2 bound
    {12'h400, 3'd0, 3'd0, 4'd0,  8'd7,  1'b1, 1'b0},  // R2 ovf
    {12'h080, 3'd0, 3'd0, 4'd0,  8'd8,  1'b1, 1'b0},  // R2 priv
    {12'h010, 3'd0, 3'd0, 4'd0,  8'd4,  1'b1, 1'b0},  // R2 illegal
    {12'h020, 3'd0, 3'd0, 4'd0,  8'd10, 1'b1, 1'b0},  // R2 line-A
    {12'h040, 3'd0, 3'd0, 4'd0,  8'd11, 1'b1, 1'b0},  // R2 line-F
    {12'h800, 3'd0, 3'd0, 4'd14, 8'd46, 1'b1, 1'b0},  // R3 trap 14
    {12'h800, 3'd0, 3'd0, 4'd0,  8'd32, 1'b1, 1'b0},  // R3 trap 0
    {12'h800, 3'd0, 3'd0, 4'd15, 8'd47, 1'b1, 1'b0},  // R3 trap 15
    {12'h002, 3'd0, 3'd0, 4'd0,  8'd2,  1'b1, 1'b0},  // R4 bus error
    {12'h001, 3'd0, 3'd0, 4'd0,  8'd0,  1'b1, 1'b0},  // R4 reset
    {12'h004, 3'd0, 3'd0, 4'd0,  8'd9,  1'b1, 1'b0},  // R4 trace
    {12'h000, 3'd3, 3'd2, 4'd0,  8'd27, 1'b1, 1'b1},  // R5 level 3
    {12'h000, 3'd1, 3'd0, 4'd0,  8'd25, 1'b1, 1'b1},  // R5 level 1
    {12'h000, 3'd2, 3'd2, 4'd0,  8'd0,  1'b0, 1'b0},  // R6 equal to mask
    {12'h000, 3'd7, 3'd7, 4'd0,  8'd31, 1'b1, 1'b1},  // R7 level 7 under full mask
    {12'h110, 3'd0, 3'd0, 4'd0,  8'd4,  1'b1, 1'b0},  // R8 illegal over divz
    {12'h802, 3'd0, 3'd0, 4'd0,  8'd2,  1'b1, 1'b0},  // R8 bus over trap
    {12'h100, 3'd5, 3'd3, 4'd0,  8'd29, 1'b1, 1'b1},  // R8 irq over divz
    {12'h004, 3'd4, 3'd0, 4'd0,  8'd9,  1'b1, 1'b0}   // R8 trace over irq
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] r, input logic [2:0] irq, input logic [2:0] msk,
                       input logic [3:0] tn);
    reset_req_i = r[0]; bus_err_i = r[1]; sr_trace_i = r[2]; instr_done_i = r[2];
    illegal_i = r[4]; line_a_i = r[5]; line_f_i = r[6]; priv_i = r[7];
    div_zero_i = r[8]; bound_i = r[9]; ovf_trap_i = r[10]; trap_i = r[11];
    trap_num_i = tn; irq_level_i = irq; sr_mask_i = msk;
  endtask

  task automatic release_strobes();
    reset_req_i = 0; bus_err_i = 0; sr_trace_i = 0; instr_done_i = 0;
    illegal_i = 0; line_a_i = 0; line_f_i = 0; priv_i = 0;
    div_zero_i = 0; bound_i = 0; ovf_trap_i = 0; trap_i = 0;
  endtask

  task automatic count_takes(input int cycles, output int takes);
    takes = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_i);
      if (take_o) takes++;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int tk;
    logic [31:0] e;
    repeat (2) @(negedge clk_i);
    // R11 reset state
    chk(!take_o && !ack_o, "R11", {take_o, ack_o}, 0);
    chk(vec_num_o == 0 && vec_addr_o == 0 && ack_level_o == 0, "R11", vec_addr_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      e = TBL[i];
      drive(e[31:20], e[19:17], e[16:14], e[13:10]);
      @(negedge clk_i);
      release_strobes();
      irq_level_i = '0;
      @(negedge clk_i);
      chk(take_o == e[1], $sformatf("R2-R8 row %0d take", i), take_o, e[1]);
      if (e[1]) begin
        chk(vec_num_o == e[9:2], $sformatf("row %0d vector", i), vec_num_o, e[9:2]);
        chk(vec_addr_o == {22'd0, e[9:2], 2'b00}, $sformatf("R1 row %0d addr", i),
            vec_addr_o, {22'd0, e[9:2], 2'b00});
        chk(ack_o == e[0], $sformatf("R5 row %0d ack", i), ack_o, e[0]);
        if (e[0]) chk(ack_level_o == e[19:17], $sformatf("R5 row %0d level", i),
                      ack_level_o, e[19:17]);
      end
      repeat (16) @(negedge clk_i);
      sr_mask_i = '0;
    end

    // R9 drain order: four strobes at once, one take per cycle
    drive(12'h710, 3'd0, 3'd0, 4'd0);
    @(negedge clk_i);
    release_strobes();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk(take_o && vec_num_o == 8'(4 + k), "R9 drain order", vec_num_o, 4 + k);
    end
    @(negedge clk_i);
    chk(!take_o, "R9 drained", take_o, 0);

    // R10 reset discards other pending requests
    drive(12'hFF7, 3'd0, 3'd0, 4'd3);
    @(negedge clk_i);
    release_strobes();
    @(negedge clk_i);
    chk(take_o && vec_num_o == 0, "R10 reset wins", vec_num_o, 0);
    count_takes(16, tk);
    chk(tk == 0, "R10 others discarded", tk, 0);

    // R7 held level 7 gives one take only
    sr_mask_i = 3'd7;
    irq_level_i = 3'd7;
    count_takes(10, tk);
    chk(tk == 1, "R7 single take on held level 7", tk, 1);
    irq_level_i = 3'd0;
    count_takes(4, tk);

    // R6 masked level held many cycles
    sr_mask_i = 3'd5;
    irq_level_i = 3'd4;
    count_takes(10, tk);
    chk(tk == 0, "R6 masked level held", tk, 0);
    irq_level_i = 3'd0;
    sr_mask_i = 3'd0;
    count_takes(4, tk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule